// File: doc/BRIEF.md
# PHY Address Discovery Sequencer

This block finds an attached Ethernet PHY by walking the whole 5-bit management address space. Each probe goes through an external management (MDIO) master over a simple request/acknowledge port. A probe reads the second identifier register (register 3). The value 0xFFFF means the address is empty. Any other value counts as a present device. The sequencer then reads the first identifier register (register 2) at the same address and stops.

A one-cycle start pulse launches a scan. If a full sweep of all 32 addresses finds nothing, the sequencer idles for a programmable number of clock cycles (about 10 ms in a real system) and sweeps again. This repeats up to a fixed number of passes. When the scan ends, a one-cycle done pulse is issued. At that point the result registers hold a found flag, the address of the device, and a 32-bit identifier: register 2 in the upper half, register 3 in the lower half.

Top module: `phy_scan_seq`

## Requirements
- R1: A start pulse while idle begins a scan one cycle later. The first request goes to address 0, register 3, with no delay before it.
- R2: Within a pass, addresses are probed in ascending order, 0 to 31, one register-3 read each. The scan stops at the first address whose register-3 data is not 0xFFFF. Any other value, 0xFFFE included, is a hit.
- R3: On a hit, exactly one register-2 read is issued at the same address. The block then reports found=1, phy_addr set to that address, and phy_id[31:16] set to the register-2 data with phy_id[15:0] set to the register-3 data.
- R4: A request (mdio_req high) holds its address and register stable until mdio_ack is seen. A single acknowledge completes a single transaction, and mdio_rdata is sampled in the acknowledge cycle.
- R5: After a pass with no hit, mdio_req stays low for exactly DELAY_CYCLES cycles. The next pass then starts again at address 0.
- R6: At most PASSES passes are made. If all of them miss, the block reports found=0, phy_addr=0 and phy_id=0.
- R7: done is high for exactly one cycle at the end of every scan. busy is high from the cycle after start until that done cycle. mdio_req is low in the done cycle.
- R8: A start pulse while busy is ignored. The ongoing scan's transactions and result are unchanged, and only one done pulse is issued.
- R9: Starting a new scan clears the previous result in the cycle after start.
- R10: After reset, busy, done, mdio_req and found are 0, and phy_addr and phy_id are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Scan launch pulse |
| mdio_req | output | 1 | Management read request, held until acknowledged |
| mdio_addr | output | 5 | PHY address of the request |
| mdio_reg | output | 5 | Register number of the request |
| mdio_ack | input | 1 | Transaction complete, one cycle |
| mdio_rdata | input | 16 | Read data, valid with mdio_ack |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| found | output | 1 | A PHY was located |
| phy_addr | output | 5 | Address of the located PHY |
| phy_id | output | 32 | Identifier, register 2 high half, register 3 low half |

## Verification
A stuck or mis-stepped address counter shows up on the first acknowledged probe after it. The request address jumps or repeats, or fails to wrap to 0 at the next pass. A pass counter that is off by one changes the total probe count and the number of quiet cycles between passes, so a failing scan reports one pass too many or too few. A delay counter fault stretches or shortens the quiet window. Result capture errors appear only at done, as a wrong found flag, address or swapped identifier halves.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

    localparam int PHY_AW = 5;
    localparam int REG_AW = 5;
    localparam int DATA_W = 16;
    localparam int ID_W   = 2 * DATA_W;

    localparam logic [PHY_AW-1:0] LAST_PHY_ADDR = '1;
    localparam logic [REG_AW-1:0] REG_ID_HI     = 5'd2;
    localparam logic [REG_AW-1:0] REG_ID_LO     = 5'd3;
    localparam logic [DATA_W-1:0] NO_DEVICE     = '1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROBE,
        S_FETCH,
        S_GAP,
        S_DONE
    } scan_state_e;

    function automatic logic is_absent(input logic [DATA_W-1:0] d);
        return d == NO_DEVICE;
    endfunction

endpackage

// File: rtl/phy_scan_delay.sv
module phy_scan_delay #(
    parameter int DELAY_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expire
);
    localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES + 1) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= CNT_W'(DELAY_CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run_q && (cnt_q == '0);

    assert_load_idle_R5: assert property (@(posedge clk) disable iff (rst)
        load |-> !run_q);

endmodule

// File: rtl/phy_scan_result.sv
module phy_scan_result
    import phy_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [PHY_AW-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              found,
    output logic [PHY_AW-1:0] phy_addr,
    output logic [ID_W-1:0]   phy_id
);
    logic [DATA_W-1:0] lo_q;
    logic [PHY_AW-1:0] hit_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q       <= '0;
            hit_addr_q <= '0;
        end else if (cap_lo) begin
            lo_q       <= data_in;
            hit_addr_q <= addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            found    <= 1'b0;
            phy_addr <= '0;
            phy_id   <= '0;
        end else if (cap_hi) begin
            found    <= 1'b1;
            phy_addr <= hit_addr_q;
            phy_id   <= {data_in, lo_q};
        end
    end

    assert_fetch_same_addr_R3: assert property (@(posedge clk) disable iff (rst)
        cap_hi |-> addr_in == hit_addr_q);

endmodule

// File: rtl/phy_scan_seq.sv
module phy_scan_seq
    import phy_scan_pkg::*;
#(
    parameter int PASSES       = 11,
    parameter int DELAY_CYCLES = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              mdio_req,
    output logic [PHY_AW-1:0] mdio_addr,
    output logic [REG_AW-1:0] mdio_reg,
    input  logic              mdio_ack,
    input  logic [DATA_W-1:0] mdio_rdata,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [PHY_AW-1:0] phy_addr,
    output logic [ID_W-1:0]   phy_id
);
    localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1;
    localparam logic [PASS_W-1:0] FINAL_PASS = PASS_W'(PASSES - 1);

    scan_state_e       state_q, state_d;
    logic [PHY_AW-1:0] addr_q;
    logic [PASS_W-1:0] pass_q;
    logic              dly_load, dly_expire;
    logic              res_clear, cap_lo, cap_hi;
    logic              probe_miss, at_last;

    assign probe_miss = (state_q == S_PROBE) && mdio_ack && is_absent(mdio_rdata);
    assign at_last    = (addr_q == LAST_PHY_ADDR);

    always_comb begin
        state_d   = state_q;
        dly_load  = 1'b0;
        res_clear = 1'b0;
        cap_lo    = 1'b0;
        cap_hi    = 1'b0;
        case (state_q)
            S_IDLE: if (start) begin
                state_d   = S_PROBE;
                res_clear = 1'b1;
            end
            S_PROBE: if (mdio_ack) begin
                if (!is_absent(mdio_rdata)) begin
                    cap_lo  = 1'b1;
                    state_d = S_FETCH;
                end else if (at_last) begin
                    if (pass_q == FINAL_PASS) begin
                        state_d = S_DONE;
                    end else begin
                        state_d  = S_GAP;
                        dly_load = 1'b1;
                    end
                end
            end
            S_FETCH: if (mdio_ack) begin
                cap_hi  = 1'b1;
                state_d = S_DONE;
            end
            S_GAP:  if (dly_expire) state_d = S_PROBE;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            pass_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                addr_q <= '0;
                pass_q <= '0;
            end else if (probe_miss) begin
                addr_q <= at_last ? '0 : addr_q + 1'b1;
                if (at_last && pass_q != FINAL_PASS) pass_q <= pass_q + 1'b1;
            end
        end
    end

    phy_scan_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_delay (
        .clk    (clk),
        .rst    (rst),
        .load   (dly_load),
        .expire (dly_expire)
    );

    phy_scan_result u_result (
        .clk      (clk),
        .rst      (rst),
        .clear    (res_clear),
        .cap_lo   (cap_lo),
        .cap_hi   (cap_hi),
        .addr_in  (addr_q),
        .data_in  (mdio_rdata),
        .found    (found),
        .phy_addr (phy_addr),
        .phy_id   (phy_id)
    );

    assign mdio_req  = (state_q == S_PROBE) || (state_q == S_FETCH);
    assign mdio_reg  = (state_q == S_FETCH) ? REG_ID_HI : REG_ID_LO;
    assign mdio_addr = addr_q;
    assign busy      = (state_q != S_IDLE);
    assign done      = (state_q == S_DONE);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_addr) && $stable(mdio_reg)));

    assert_ascend_R2: assert property (@(posedge clk) disable iff (rst)
        (probe_miss && !at_last) |=> (mdio_req && mdio_addr == PHY_AW'($past(mdio_addr) + 1)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_found_at_end_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(found) |-> done);

    assert_pass_limit_R6: assert property (@(posedge clk) disable iff (rst)
        pass_q <= FINAL_PASS);

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> busy);

    assert_gap_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_GAP && !dly_expire) |=> (state_q == S_GAP && !mdio_req));

endmodule

// File: tb/test_phy_scan_seq.sv
module test_phy_scan_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 20;
    localparam int NPASS      = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mdio_req;
    logic [4:0]  mdio_addr;
    logic [4:0]  mdio_reg;
    logic        mdio_ack = 1'b0;
    logic [15:0] mdio_rdata = 16'h0;
    logic        busy, done, found;
    logic [4:0]  phy_addr;
    logic [31:0] phy_id;

    int checks = 0;
    int fails  = 0;

    // PHY model configuration
    int          phy_a = -1, phy_b = -1, appear = 1;
    logic [15:0] id_hi = 16'h0022, id_lo = 16'h1619;

    // observation counters
    int probes, passes, fetches, quiet, done_cnt, order_err, fetch_err;
    int last_probe, first_addr, first_reg, seen_first;
    logic [15:0] last_lo_data;
    logic ack_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_scan_seq #(.PASSES(NPASS), .DELAY_CYCLES(DLY)) i_phy_scan_seq (
        .clk(clk), .rst(rst), .start(start),
        .mdio_req(mdio_req), .mdio_addr(mdio_addr), .mdio_reg(mdio_reg),
        .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata),
        .busy(busy), .done(done), .found(found),
        .phy_addr(phy_addr), .phy_id(phy_id)
    );

    function automatic logic present(input int a);
        return ((a == phy_a) || (a == phy_b)) && (passes >= appear);
    endfunction

    // responder and monitor, driven on falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (done) done_cnt++;
            if (busy && !mdio_req) quiet++;
            if (mdio_req && !seen_first) begin
                seen_first = 1; first_addr = int'(mdio_addr); first_reg = int'(mdio_reg);
            end
            mdio_ack = 1'b0;
            if (mdio_req && !ack_prev) begin
                mdio_ack = 1'b1;
                if (mdio_reg == 5'd3) begin
                    if (mdio_addr == 5'd0) passes++;
                    if (int'(mdio_addr) != ((last_probe + 1) % 32)) order_err++;
                    last_probe = int'(mdio_addr);
                    probes++;
                    mdio_rdata = present(int'(mdio_addr)) ? id_lo : 16'hFFFF;
                    last_lo_data = mdio_rdata;
                end else if (mdio_reg == 5'd2) begin
                    fetches++;
                    if (int'(mdio_addr) != last_probe || last_lo_data == 16'hFFFF) fetch_err++;
                    mdio_rdata = id_hi;
                end else begin
                    fetch_err++;
                    mdio_rdata = 16'h0;
                end
            end
            ack_prev = mdio_ack;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_scan(input int a, input int b, input int app, input int extra_at);
        int n;
        phy_a = a; phy_b = b; appear = app;
        probes = 0; passes = 0; fetches = 0; quiet = 0; done_cnt = 0;
        order_err = 0; fetch_err = 0; last_probe = 31; seen_first = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R9 result cleared after start", {31'b0, found}, 32'd0);
        check("R7 busy after start", {31'b0, busy}, 32'd1);
        n = 0;
        while (done_cnt == 0 && n < 20000) begin
            n++;
            if (n == extra_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        repeat (3) @(negedge clk);
        check("R7 single done pulse", done_cnt, 1);
        check("R7 idle after done", {31'b0, busy}, 32'd0);
        check("R1 first request address", first_addr, 0);
        check("R1 first request register", first_reg, 3);
        check("R2 ascending probe order", order_err, 0);
        check("R4 one transaction per ack, fetch after hit", fetch_err, 0);
    endtask

    task automatic test_reset;
        check("R10 busy", {31'b0, busy}, 0);
        check("R10 done", {31'b0, done}, 0);
        check("R10 req", {31'b0, mdio_req}, 0);
        check("R10 found", {31'b0, found}, 0);
        check("R10 addr", {27'b0, phy_addr}, 0);
        check("R10 id", phy_id, 0);
    endtask

    task automatic test_hit(input int a, input logic [15:0] lo, input string tag);
        id_lo = lo;
        run_scan(a, -1, 1, 0);
        check({tag, " R3 found"}, {31'b0, found}, 1);
        check({tag, " R3 addr"}, {27'b0, phy_addr}, a);
        check({tag, " R3 id"}, phy_id, {id_hi, lo});
        check({tag, " R2 probes"}, probes, a + 1);
        check({tag, " R3 one fetch"}, fetches, 1);
        check({tag, " R5 no gap on pass 1"}, quiet, 1);
    endtask

    task automatic test_none;
        id_lo = 16'h1619;
        run_scan(-1, -1, 1, 0);
        check("R6 not found", {31'b0, found}, 0);
        check("R6 addr zero", {27'b0, phy_addr}, 0);
        check("R6 id zero", phy_id, 0);
        check("R6 pass count", passes, NPASS);
        check("R6 probe count", probes, NPASS * 32);
        check("R5 quiet cycles between passes", quiet, (NPASS - 1) * DLY + 1);
        check("R3 no fetch on miss", fetches, 0);
    endtask

    task automatic test_late;
        id_lo = 16'h7A01;
        run_scan(5, -1, 3, 0);
        check("R5 late found", {31'b0, found}, 1);
        check("R5 late addr", {27'b0, phy_addr}, 5);
        check("R5 late passes", passes, 3);
        check("R5 late probes", probes, 64 + 6);
        check("R5 late quiet", quiet, 2 * DLY + 1);
    endtask

    task automatic test_two;
        id_lo = 16'h0BB0;
        run_scan(9, 4, 1, 0);
        check("R2 lowest address wins", {27'b0, phy_addr}, 4);
        check("R2 stop at first", probes, 5);
    endtask

    task automatic test_restart;
        id_lo = 16'h1234;
        run_scan(17, -1, 1, 10);
        check("R8 found unaffected", {31'b0, found}, 1);
        check("R8 addr unaffected", {27'b0, phy_addr}, 17);
        check("R8 probes unaffected", probes, 18);
        check("R8 passes unaffected", passes, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_hit(0, 16'h1619, "addr0");
        test_hit(17, 16'h5C90, "addr17");
        test_hit(31, 16'hFFFE, "addr31 FFFE");
        test_none();
        test_late();
        test_two();
        test_restart();
        test_hit(12, 16'h0001, "rescan");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule